// File: doc/BRIEF.md
# PAM4 Lane Precoding Decoder

This block is the receive stage of one serial lane that reverses the transmit-side coding of a four-level link. It takes one 2-bit value per unit interval, already recovered from the PAM4 voltage. With each value it takes a flag saying whether both bits of the pair were scrambled and a marker for training-sequence-zero content. A plain enable selects whether precoding is in use on the lane. The block first removes the 1/(1+D) precoding by adding each received value to the previous one, modulo 4. It then reverses the Gray mapping and packs four pairs into an 8-bit symbol for a descrambler further down the lane.

The add-previous decoder turns a burst of received values that are all off by the same offset of two levels into just two wrong output pairs: one where the burst starts and one just after it ends. The cost is that a single wrong value spoils two outputs. The stored history is cleared to 00 whenever a pair is passed through without decoding, which matches the transmitter restarting its own history.

Both data edges are valid/ready streams. A pair is accepted in a cycle where `in_valid` and `in_ready` are both high. A symbol is delivered in a cycle where `out_valid` and `out_ready` are both high. While a symbol is waiting and `out_ready` is low, the symbol is held steady and `in_ready` is low. The input side therefore stalls as a whole and never drops a pair.

Top module: `lane_precode_rx`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: An accepted pair is decoded when `precode_en` is 1, `in_scrambled` is 1 and `in_ts0` is 0. Its decoded value is (received + previous stored value) mod 4.
- R3: After any accepted pair that is not decoded, the stored previous value is 00. The next decoded pair then equals its own received value.
- R4: An accepted pair that is not decoded is passed to the Gray stage unchanged.
- R5: The Gray stage maps the decoded value 00 to 00, 01 to 01, 11 to 10 and 10 to 11.
- R6: Four accepted pairs form one symbol, least significant first: the first pair goes to bits [1:0] and the fourth to bits [7:6]. `out_valid` rises in the cycle after the fourth pair is accepted.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sym` does not change.
- R8: Cycles without an accepted pair leave the stored previous value and the packing position unchanged.
- R9: A run of received values each shifted by +2 mod 4 produces exactly two wrong output pairs: the first pair of the run and the pair right after it.
- R10: A single received value shifted by +1 mod 4 produces exactly two wrong output pairs: that pair and the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| precode_en | input | 1 | Precoding in use on this lane |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can accept a pair |
| in_pair | input | 2 | Value recovered from the PAM4 level |
| in_scrambled | input | 1 | Both bits of this pair were scrambled |
| in_ts0 | input | 1 | Pair belongs to training-sequence-zero content |
| out_valid | output | 1 | Packed symbol present |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 8 | Packed symbol, first pair in the low bits |

## Verification
The bench builds the block with its default of four pairs per symbol. This gives an 8-bit output, so a byte-level check against a known four-pair pattern covers both the Gray table and the packing order. The run randomises `out_ready` and inserts input idle cycles, which exercises stalls landing on every packing position and between decoded pairs. Clean and corrupted copies of the same sequence are compared to measure how far a burst or a single error spreads.

// File: rtl/lane_pc_pkg.sv
package lane_pc_pkg;
  localparam int PAIR_W = 2;
  typedef logic [PAIR_W-1:0] pam_pair_t;
endpackage

// File: rtl/pc_undo.sv
module pc_undo
  import lane_pc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      apply,
  input  pam_pair_t rx,
  output pam_pair_t dec,
  output pam_pair_t hist
);
  pam_pair_t hist_q;

  // modulo-4 add falls out of the 2-bit width
  always_comb begin
    if (apply) dec = rx + hist_q;
    else       dec = rx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    hist_q <= '0;
    else if (take) hist_q <= apply ? rx : '0;
  end

  assign hist = hist_q;
endmodule

// File: rtl/gray_undo.sv
module gray_undo #(
  parameter int W = 2
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/pair_packer.sv
module pair_packer #(
  parameter int PAIRS = 4,
  parameter int PW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PW-1:0]     in_pair,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAIRS*PW-1:0] out_data
);
  localparam int CW = (PAIRS > 2) ? $clog2(PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

  logic [CW-1:0]         cnt_q;
  logic [PAIRS-2:0][PW-1:0] acc_q;
  logic [PAIRS*PW-1:0]   word;
  logic                  fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    for (int k = 0; k < PAIRS - 1; k++) word[k*PW +: PW] = acc_q[k];
    word[(PAIRS-1)*PW +: PW] = in_pair;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire) begin
        if (cnt_q == LAST) begin
          out_data  <= word;
          out_valid <= 1'b1;
          cnt_q     <= '0;
        end else begin
          acc_q[cnt_q] <= in_pair;
          cnt_q        <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_precode_rx.sv
module lane_precode_rx
  import lane_pc_pkg::*;
#(
  parameter int PAIRS_PER_SYM = 4,
  localparam int SYM_W = PAIRS_PER_SYM * PAIR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             precode_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_pair,
  input  logic             in_scrambled,
  input  logic             in_ts0,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_sym
);
  logic      take, apply;
  pam_pair_t dec_pair, bin_pair, hist_q;

  assign take  = in_valid && in_ready;
  assign apply = precode_en && in_scrambled && !in_ts0;

  pc_undo u_undo (
    .clk(clk), .rst_n(rst_n), .take(take), .apply(apply),
    .rx(in_pair), .dec(dec_pair), .hist(hist_q)
  );

  gray_undo #(.W(PAIR_W)) u_gray (.gray(dec_pair), .bin(bin_pair));

  pair_packer #(.PAIRS(PAIRS_PER_SYM), .PW(PAIR_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pair(bin_pair),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_sym)
  );
endmodule

// File: rtl/lane_precode_rx_chk.sv
module lane_precode_rx_chk #(
  parameter int PAIRS = 4,
  parameter int SW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          precode_en,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_scrambled,
  input logic          in_ts0,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_sym,
  input logic [1:0]    hist
);
  int  seen;
  logic fire;
  assign fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 0;
    else if (fire) seen <= (seen == PAIRS - 1) ? 0 : seen + 1;
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hist_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(precode_en && in_scrambled && !in_ts0)) |=> (hist == 2'b00));

  p_hist_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(hist));

  p_pack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen == PAIRS - 1) |=> out_valid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fire));
endmodule

bind lane_precode_rx lane_precode_rx_chk #(.PAIRS(PAIRS_PER_SYM), .SW(SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .precode_en(precode_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_scrambled(in_scrambled), .in_ts0(in_ts0),
  .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym), .hist(hist_q)
);

// File: tb/sim_lane_precode_rx.sv
module sim_lane_precode_rx;
  logic clk = 0, rst_n = 0;
  logic precode_en = 0, in_valid = 0, in_scrambled = 0, in_ts0 = 0, out_ready = 1;
  logic [1:0] in_pair = 0;
  logic in_ready, out_valid;
  logic [7:0] out_sym;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit rand_ready = 0;
  logic [7:0] got[$];

  // behavioural reference state
  int  m_hist = 0, m_acc = 0, m_cnt = 0, m_byte = 0;
  bit  m_v = 0;

  always #2 clk = ~clk;

  lane_precode_rx u0 (
    .clk(clk), .rst_n(rst_n), .precode_en(precode_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_pair(in_pair), .in_scrambled(in_scrambled),
    .in_ts0(in_ts0), .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym)
  );

  function automatic int ungray(int v);
    case (v)
      0: return 0;
      1: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist = 0; m_acc = 0; m_cnt = 0; m_v = 0; m_byte = 0;
    end else begin
      bit take;
      take = in_valid && (!m_v || out_ready);
      if (m_v && out_ready) m_v = 0;
      if (take) begin
        int p;
        bit dec;
        dec = precode_en && in_scrambled && !in_ts0;
        p = dec ? (int'(in_pair) + m_hist) % 4 : int'(in_pair);
        m_hist = dec ? int'(in_pair) : 0;
        m_acc = m_acc | (ungray(p) << (2 * m_cnt));
        m_cnt++;
        if (m_cnt == 4) begin
          m_byte = m_acc; m_v = 1; m_acc = 0; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({tag, " out_valid"}, int'(out_valid), int'(m_v));
      check("R7 in_ready", int'(in_ready), int'(!m_v || out_ready));
      if (m_v) check({tag, " out_sym"}, int'(out_sym), m_byte);
      if (out_valid && out_ready) got.push_back(out_sym);
    end
    if (rand_ready) out_ready <= ($urandom % 3) != 0;
    else            out_ready <= 1'b1;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(int r, bit scr, bit ts0, bit gaps);
    bit acc;
    @(negedge clk);
    if (gaps && ($urandom % 4 == 0)) begin
      in_valid = 0;
      @(negedge clk);
    end
    in_valid = 1; in_pair = 2'(r); in_scrambled = scr; in_ts0 = ts0;
    do begin
      #1 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    rand_ready = 0;
    repeat (6) @(negedge clk);
  endtask

  function automatic int pair_of(int idx);
    return (got[idx / 4] >> (2 * (idx % 4))) & 3;
  endfunction

  initial begin
    int base[12];
    int clean[12];
    int diffs;
    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    rst_n = 1;

    // R2: decoded stream
    tag = "R2"; precode_en = 1;
    send(0, 0, 0, 0);
    for (int i = 0; i < 63; i++) send($urandom % 4, 1, 0, 0);
    drain();
    // R3: history cleared by unscrambled / TS0 pairs
    tag = "R3";
    for (int i = 0; i < 64; i++) send($urandom % 4, ($urandom % 3) != 0, ($urandom % 5) == 0, 0);
    drain();
    // R4: precoding off
    tag = "R4"; precode_en = 0;
    for (int i = 0; i < 32; i++) send($urandom % 4, 1, 0, 0);
    drain();
    // R5 / R6: known pattern, bypass
    got.delete();
    send(0, 1, 0, 0); send(1, 1, 0, 0); send(2, 1, 0, 0); send(3, 1, 0, 0);
    drain();
    check("R5 R6 packed gray", int'(got.size() > 0 ? got[0] : 8'h00), 8'hB4);
    // R7 / R8: back-pressure and idle gaps
    tag = "R7 R8"; precode_en = 1; rand_ready = 1;
    for (int i = 0; i < 200; i++) send($urandom % 4, ($urandom % 6) != 0, 0, 1);
    drain();

    // R9 / R10: error spreading
    tag = "R9";
    for (int i = 0; i < 12; i++) base[i] = $urandom % 4;
    got.delete();
    for (int i = 0; i < 12; i++) send(base[i], i != 0, 0, 0);
    drain();
    for (int i = 0; i < 12; i++) clean[i] = pair_of(i);
    got.delete();
    for (int i = 0; i < 12; i++) send((i >= 3 && i <= 8) ? (base[i] + 2) % 4 : base[i], i != 0, 0, 0);
    drain();
    diffs = 0;
    for (int i = 0; i < 12; i++) if (pair_of(i) != clean[i]) diffs++;
    check("R9 burst diffs", diffs, 2);
    check("R9 burst start", int'(pair_of(3) != clean[3]), 1);
    check("R9 burst end", int'(pair_of(9) != clean[9]), 1);
    tag = "R10";
    got.delete();
    for (int i = 0; i < 12; i++) send((i == 5) ? (base[i] + 1) % 4 : base[i], i != 0, 0, 0);
    drain();
    diffs = 0;
    for (int i = 0; i < 12; i++) if (pair_of(i) != clean[i]) diffs++;
    check("R10 single diffs", diffs, 2);
    check("R10 next pair", int'(pair_of(6) != clean[6]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule